// File: doc/BRIEF.md
# Dual 8-bit Compare-Match Timer/Counter

This block holds two independent 8-bit up-counters, called channel A and channel B, controlled by one shared 8-bit mode register. Each channel counts from 00H up to the value in its own compare register. On the step after the two are equal, the counter returns to 00H and raises a sticky interrupt flag. The count rate of each channel is a prescaled system clock: divide by 4, 16 or 64. Channel A can instead count falling edges on an external event pin. Channel B toggles an output flip-flop on every compare match, so a square wave can be produced on a pin.

The counter and its compare register sit behind one bus location. A write strobe loads the compare register, and the read path always shows the live count. Software starts a channel by writing 1 to its start bit, which clears the counter and restarts its prescaler. Writing 0 freezes the count. Channel A has a continue control that lets a start write resume from the frozen value instead of clearing it. Interrupt flags are cleared by a write-one strobe per channel.

Top module: `dual_match_timer`

## Requirements
- R1: After reset the mode register reads 00H, both counters read 00H, both interrupt flags are 0 and the toggle output is 0.
- R2: Clock select code 01 advances a running counter once every 4 cycles, 10 every 16 cycles and 11 every 64 cycles. The first advance lands exactly one divide period after the start write.
- R3: A counter whose value equals its compare value returns to 00H on its next advance and sets its interrupt flag, so a match repeats every (compare+1) advances.
- R4: A mode write with a channel's start bit at 1 (channel A only when bit 3 is 0) clears that counter to 00H and restarts its prescaler. While the start bit is 0 the counter holds its value.
- R5: For channel A, a start write with the continue bit (bit 3) at 1 resumes counting from the held value without clearing it.
- R6: With channel A select code 00, the counter advances once per 1-to-0 transition of the event pin, visible on the count port three cycles after the pin falls. Rising edges and a steady level do not advance it.
- R7: Channel B with select code 00 does not count.
- R8: A compare write loads that channel's compare register and leaves the counter unchanged. The count port always returns the live counter.
- R9: An interrupt flag stays set until a clear strobe for that channel. A match in the same cycle as the clear strobe keeps the flag set.
- R10: The toggle output inverts on every channel B compare match.
- R11: Mode layout: bits 1:0 A select, bit 2 A start, bit 3 A continue, bits 5:4 B select, bit 6 B start. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode register |
| cmp_a_we | input | 1 | Write strobe for channel A compare register |
| cmp_b_we | input | 1 | Write strobe for channel B compare register |
| wdata | input | 8 | Write data for all three strobes |
| flag_clr | input | 2 | Write-one clear of interrupt flags (bit 0 A, bit 1 B) |
| event_pin | input | 1 | Asynchronous external event input for channel A |
| mode_q | output | 8 | Mode register readback |
| count_a | output | 8 | Channel A live counter |
| count_b | output | 8 | Channel B live counter |
| irq_flag | output | 2 | Sticky interrupt flags (bit 0 A, bit 1 B) |
| tog_out | output | 1 | Channel B match toggle output |

## Verification
Channel A runs with divide-by-4 and compare 3, and the count is sampled one cycle before and on each expected advance. This separates a correct prescaler phase from an off-by-one start. Divide-by-16 and divide-by-64 runs on the two channels catch a swapped select decode. A stop, resume and restart sequence tells the continue path apart from the clearing path. A clear strobe placed exactly on a match edge exposes a wrong priority. Event-pin patterns with long low levels, rising edges and repeated falls show that only falling transitions are counted, and that each is counted once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W  = 8;
    localparam int MAX_DIV = 64;
    localparam int PRE_W   = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        CKS_EXT   = 2'b00,
        CKS_DIV4  = 2'b01,
        CKS_DIV16 = 2'b10,
        CKS_DIV64 = 2'b11
    } cks_e;

    typedef struct packed {
        logic rsv;
        logic b_start;
        cks_e b_cks;
        logic a_cont;
        logic a_start;
        cks_e a_cks;
    } mode_t;

    function automatic logic [PRE_W-1:0] div_mask(input cks_e sel);
        logic [PRE_W-1:0] m;
        case (sel)
            CKS_DIV4:  m = PRE_W'(3);
            CKS_DIV16: m = PRE_W'(15);
            CKS_DIV64: m = PRE_W'(63);
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr_event_sync.sv
module tmr_event_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    input  cks_e cks_i,
    output logic tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(cks_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (run_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cks_i != CKS_EXT) && ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int  W       = 8,
    parameter bit  HAS_TOG = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic         cmp_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         tog_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cmp_q;
    logic         flag_q;
    logic         hit;

    assign hit = adv_i && !clr_i && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (cmp_we_i) begin
            cmp_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= hit | (flag_q & ~flag_clr_i);
        end
    end

    generate
        if (HAS_TOG) begin : g_tog
            logic tog_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tog_q <= 1'b0;
                end else if (hit) begin
                    tog_q <= ~tog_q;
                end
            end
            assign tog_o = tog_q;
        end else begin : g_no_tog
            assign tog_o = 1'b0;
        end
    endgenerate

    assign count_o = cnt_q;
    assign flag_o  = flag_q;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              cmp_a_we,
    input  logic              cmp_b_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        flag_clr,
    input  logic              event_pin,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] count_a,
    output logic [DATA_W-1:0] count_b,
    output logic [1:0]        irq_flag,
    output logic              tog_out
);
    localparam int NCH = 2;

    mode_t mode_r;
    mode_t wmode;
    logic  ev_fall;

    cks_e              cks   [NCH];
    logic [NCH-1:0]    run;
    logic [NCH-1:0]    pre_clr;
    logic [NCH-1:0]    cnt_clr;
    logic [NCH-1:0]    pre_tick;
    logic [NCH-1:0]    adv;
    logic [NCH-1:0]    cmp_we;
    logic [NCH-1:0]    tog;
    logic [DATA_W-1:0] cnt [NCH];

    assign wmode = mode_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= '0;
        end else if (mode_we) begin
            mode_r     <= wmode;
            mode_r.rsv <= 1'b0;
        end
    end

    assign cks[0]     = mode_r.a_cks;
    assign cks[1]     = mode_r.b_cks;
    assign run[0]     = mode_r.a_start;
    assign run[1]     = mode_r.b_start;
    assign pre_clr[0] = mode_we & wmode.a_start;
    assign pre_clr[1] = mode_we & wmode.b_start;
    assign cnt_clr[0] = mode_we & wmode.a_start & ~wmode.a_cont;
    assign cnt_clr[1] = mode_we & wmode.b_start;
    assign cmp_we     = {cmp_b_we, cmp_a_we};

    tmr_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (event_pin),
        .fall_o (ev_fall)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            tmr_prescaler u_pre (
                .clk    (clk),
                .rst    (rst),
                .clr_i  (pre_clr[i]),
                .run_i  (run[i]),
                .cks_i  (cks[i]),
                .tick_o (pre_tick[i])
            );

            if (i == 0) begin : g_ext
                assign adv[i] = pre_tick[i] |
                                (run[i] && (cks[i] == CKS_EXT) && ev_fall);
            end else begin : g_int
                assign adv[i] = pre_tick[i];
            end

            tmr_channel #(.W(DATA_W), .HAS_TOG(i == 1)) u_ch (
                .clk        (clk),
                .rst        (rst),
                .clr_i      (cnt_clr[i]),
                .adv_i      (adv[i]),
                .cmp_we_i   (cmp_we[i]),
                .wdata_i    (wdata),
                .flag_clr_i (flag_clr[i]),
                .count_o    (cnt[i]),
                .flag_o     (irq_flag[i]),
                .tog_o      (tog[i])
            );
        end
    endgenerate

    assign mode_q  = mode_r;
    assign count_a = cnt[0];
    assign count_b = cnt[1];
    assign tog_out = tog[1];
endmodule

// File: rtl/dual_match_timer_chk.sv
module dual_match_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_we,
    input logic [1:0] flag_clr,
    input logic [7:0] mode_q,
    input logic [7:0] count_a,
    input logic [7:0] count_b,
    input logic [1:0] irq_flag,
    input logic       tog_out
);
    assert_wrap_a_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[0]) |-> count_a == 8'd0);

    assert_wrap_b_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[1]) |-> count_b == 8'd0);

    assert_step_a_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_a) |-> (count_a == $past(count_a) + 8'd1) || (count_a == 8'd0));

    assert_hold_a_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(mode_q[2]) && !$past(mode_we)) |-> $stable(count_a));

    assert_b_ext_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(mode_q[5:4]) == 2'b00) && !$past(mode_we)) |-> $stable(count_b));

    assert_flag_a_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag[0]) |-> $past(flag_clr[0]));

    assert_flag_b_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag[1]) |-> $past(flag_clr[1]));

    assert_tog_on_match_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(tog_out) |-> count_b == 8'd0);

    assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (rst)
        mode_q[7] == 1'b0);
endmodule

bind dual_match_timer dual_match_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_we  (mode_we),
    .flag_clr (flag_clr),
    .mode_q   (mode_q),
    .count_a  (count_a),
    .count_b  (count_b),
    .irq_flag (irq_flag),
    .tog_out  (tog_out)
);

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic       cmp_a_we = 1'b0;
    logic       cmp_b_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [1:0] flag_clr = 2'b00;
    logic       event_pin = 1'b1;
    logic [7:0] mode_q;
    logic [7:0] count_a;
    logic [7:0] count_b;
    logic [1:0] irq_flag;
    logic       tog_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef enum int {SIG_CNT_A, SIG_CNT_B, SIG_FLAG_A, SIG_FLAG_B, SIG_TOG, SIG_MODE} sig_e;
    typedef struct {
        string req;
        sig_e  sig;
        int    exp;
    } item_t;

    item_t q[$];
    event  item_ev;

    always #5 clk = ~clk;

    dual_match_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_we   (mode_we),
        .cmp_a_we  (cmp_a_we),
        .cmp_b_we  (cmp_b_we),
        .wdata     (wdata),
        .flag_clr  (flag_clr),
        .event_pin (event_pin),
        .mode_q    (mode_q),
        .count_a   (count_a),
        .count_b   (count_b),
        .irq_flag  (irq_flag),
        .tog_out   (tog_out)
    );

    function automatic int sample(sig_e s);
        case (s)
            SIG_CNT_A:  return int'(count_a);
            SIG_CNT_B:  return int'(count_b);
            SIG_FLAG_A: return int'(irq_flag[0]);
            SIG_FLAG_B: return int'(irq_flag[1]);
            SIG_TOG:    return int'(tog_out);
            default:    return int'(mode_q);
        endcase
    endfunction

    function automatic void score(item_t it);
        int act;
        act = sample(it.sig);
        n_chk++;
        if (act != it.exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", it.req, it.sig.name(), act, it.exp);
        end
    endfunction

    initial begin : monitor
        forever begin
            @(item_ev);
            while (q.size() > 0) score(q.pop_front());
        end
    end

    task automatic expect_v(string req, sig_e s, int v);
        item_t it;
        it.req = req;
        it.sig = s;
        it.exp = v;
        q.push_back(it);
        -> item_ev;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(logic [7:0] v);
        mode_we = 1'b1;
        wdata   = v;
        step(1);
        mode_we = 1'b0;
    endtask

    task automatic write_cmp(bit ch_b, logic [7:0] v);
        cmp_a_we = !ch_b;
        cmp_b_we = ch_b;
        wdata    = v;
        step(1);
        cmp_a_we = 1'b0;
        cmp_b_we = 1'b0;
    endtask

    task automatic clear_flag(int ch);
        flag_clr[ch] = 1'b1;
        step(1);
        flag_clr = 2'b00;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : driver
        step(3);
        rst = 1'b0;
        // R1 reset state
        expect_v("R1", SIG_MODE, 0);
        expect_v("R1", SIG_CNT_A, 0);
        expect_v("R1", SIG_CNT_B, 0);
        expect_v("R1", SIG_FLAG_A, 0);
        expect_v("R1", SIG_FLAG_B, 0);
        expect_v("R1", SIG_TOG, 0);

        // R2 / R3: channel A divide-by-4, compare 3
        write_cmp(1'b0, 8'd3);
        expect_v("R8", SIG_CNT_A, 0);
        write_mode(8'h05);
        expect_v("R11", SIG_MODE, 8'h05);
        expect_v("R4", SIG_CNT_A, 0);
        step(3);  expect_v("R2", SIG_CNT_A, 0);
        step(1);  expect_v("R2", SIG_CNT_A, 1);
        step(8);  expect_v("R2", SIG_CNT_A, 3);
        step(3);  expect_v("R3", SIG_CNT_A, 3);
        expect_v("R3", SIG_FLAG_A, 0);
        step(1);  expect_v("R3", SIG_CNT_A, 0);
        expect_v("R3", SIG_FLAG_A, 1);

        // R9: clear, then clear coinciding with a match
        step(1);
        clear_flag(0);                     // now 18 cycles after start
        expect_v("R9", SIG_FLAG_A, 0);
        step(29);                          // 47
        clear_flag(0);                     // strobe sits on the match edge at 48
        expect_v("R9", SIG_FLAG_A, 1);
        expect_v("R3", SIG_CNT_A, 0);

        // R4 stop holds: write edge at 56 still takes its advance, count 2
        step(7);
        write_mode(8'h01);
        expect_v("R4", SIG_CNT_A, 2);
        step(20); expect_v("R4", SIG_CNT_A, 2);

        // R5 resume with continue bit
        write_mode(8'h0D);
        expect_v("R5", SIG_CNT_A, 2);
        step(3);  expect_v("R5", SIG_CNT_A, 2);
        step(1);  expect_v("R5", SIG_CNT_A, 3);

        // R4 restart clears
        write_mode(8'h05);
        expect_v("R4", SIG_CNT_A, 0);

        // R2 divide-by-16 with compare 1
        write_cmp(1'b0, 8'd1);
        write_mode(8'h06);
        expect_v("R4", SIG_CNT_A, 0);
        step(15); expect_v("R2", SIG_CNT_A, 0);
        step(1);  expect_v("R2", SIG_CNT_A, 1);
        step(16); expect_v("R3", SIG_CNT_A, 0);

        // Channel B divide-by-64, compare 1
        write_cmp(1'b1, 8'd1);
        write_mode(8'h70);
        expect_v("R11", SIG_MODE, 8'h70);
        step(63); expect_v("R2", SIG_CNT_B, 0);
        step(1);  expect_v("R2", SIG_CNT_B, 1);
        expect_v("R10", SIG_TOG, 0);
        step(64); expect_v("R3", SIG_CNT_B, 0);
        expect_v("R10", SIG_TOG, 1);
        expect_v("R3", SIG_FLAG_B, 1);

        // R10 toggles at divide-by-4
        write_mode(8'h50);
        expect_v("R4", SIG_CNT_B, 0);
        expect_v("R10", SIG_TOG, 1);
        step(7);  expect_v("R10", SIG_TOG, 1);
        step(1);  expect_v("R10", SIG_TOG, 0);
        step(8);  expect_v("R10", SIG_TOG, 1);

        // R8 compare write keeps the counter
        step(4);  expect_v("R8", SIG_CNT_B, 1);
        write_cmp(1'b1, 8'd5);
        expect_v("R8", SIG_CNT_B, 1);

        // R7 channel B with code 00 stays still
        write_mode(8'h40);
        expect_v("R7", SIG_CNT_B, 0);
        step(30); expect_v("R7", SIG_CNT_B, 0);

        // R6 event counting on channel A, compare 2
        clear_flag(0);
        expect_v("R9", SIG_FLAG_A, 0);
        write_cmp(1'b0, 8'd2);
        write_mode(8'h84);
        expect_v("R11", SIG_MODE, 8'h04);
        expect_v("R6", SIG_CNT_A, 0);
        event_pin = 1'b0;
        step(2);  expect_v("R6", SIG_CNT_A, 0);
        step(1);  expect_v("R6", SIG_CNT_A, 1);
        step(10); expect_v("R6", SIG_CNT_A, 1);
        event_pin = 1'b1;
        step(5);  expect_v("R6", SIG_CNT_A, 1);
        event_pin = 1'b0;
        step(3);  expect_v("R6", SIG_CNT_A, 2);
        expect_v("R6", SIG_FLAG_A, 0);
        event_pin = 1'b1;
        step(3);
        event_pin = 1'b0;
        step(3);  expect_v("R6", SIG_CNT_A, 0);
        expect_v("R3", SIG_FLAG_A, 1);

        step(2);
        while (q.size() > 0) score(q.pop_front());
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule